// File: doc/BRIEF.md
# Flash Toggle-Bit Completion Poller

This block runs on the host side of a parallel NOR flash. After software has launched an embedded program or erase operation, a start pulse hands the wait to this block. It reads the device status byte over a simple request/acknowledge read port and decides whether the operation finished or failed. It then reports the result with a one-cycle done or fail pulse.

The decision rests on two status bits. The first is a bit that flips on every status read while the device is busy (bit 6). The second is a bit the device raises once an operation has run past its time limit (bit 5). Toggling can stop at the same moment the time-limit bit rises. For that reason, a set time-limit bit does not cause an immediate failure: the block first takes a second pair of reads and checks again. A typical cause of such a failure is an attempt to program a 1 into a cell that already holds 0, because only an erase can turn a 0 back into a 1.

When the block declares a failure, it first writes the reset command so that the device returns to array-read mode, and only then reports fail. A configurable limit on the number of polling pairs also ends the wait with the same reset-then-fail path. This prevents a stuck or dead bus from hanging the host.

Top module: `nor_toggle_poller`

## Requirements
- R1: After reset, busy, done, fail, rdReq and wrReq are all low.
- R2: A start pulse while idle begins a pair of status reads. If bit 6 is equal in both reads, done pulses, fail stays low and no write is issued.
- R3: If bit 6 differs within a pair and bit 5 of the second (most recent) read of that pair is 0, the block begins a new pair of reads. Bit 5 of the first read of the pair has no effect.
- R4: If bit 6 differs and bit 5 of the most recent read is 1, exactly two more reads follow. If bit 6 is equal between those two reads, done pulses with no write.
- R5: If bit 6 still differs on that recheck, the block writes the byte RESET_CMD (default 0xF0) and holds wrReq until wrAck. Fail pulses only after that write is acknowledged.
- R6: When MAX_PAIRS pairs have all shown toggling with bit 5 at 0, the block issues no further read, writes RESET_CMD, and then pulses fail.
- R7: busy rises on the cycle after an accepted start and stays high through the done or fail pulse. A start while busy is ignored.
- R8: done and fail are single-cycle pulses and never occur together. rdReq and wrReq are never high together, and each is held until its acknowledge.
- R9: fail is high in the cycle right after the clock edge that accepts the reset write. done is high one cycle after the edge that accepts the final read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Pulse that begins polling when idle |
| rdReq | output | 1 | Status read request, held until rdAck |
| rdAck | input | 1 | Read acknowledge; rdData valid in the same cycle |
| rdData | input | DATA_W | Status byte returned by the device |
| wrReq | output | 1 | Reset-command write request, held until wrAck |
| wrAck | input | 1 | Write acknowledge |
| wrData | output | DATA_W | Command byte for the write (RESET_CMD) |
| busy | output | 1 | High while a poll is in progress |
| done | output | 1 | One-cycle pulse: operation completed |
| fail | output | 1 | One-cycle pulse: operation failed or timed out |

## Verification
The assertions check the handshake rules and pulse shape on every cycle. These include held requests, mutually exclusive requests and pulses, the busy envelope, the reset byte on every write, and fail appearing only after an acknowledged write. Which outcome a given sequence of status bytes should produce, and how many reads it takes, only the bench scenarios can show. Examples are a toggle that stops exactly as bit 5 rises, bit 5 set only in the first read of a pair, and the pair limit running out. The bench also covers the exact cycle of done and fail relative to the final acknowledge.

// File: rtl/nor_poll_pkg.sv
package nor_poll_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_RD1,
    ST_RD2,
    ST_EVAL,
    ST_RC1,
    ST_RC2,
    ST_RCEVAL,
    ST_RSTWR,
    ST_DONE,
    ST_FAIL
  } pollState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capFirst;
    logic capSecond;
    logic clrPairs;
    logic incPairs;
  } dpStrobe_t;

endpackage

// File: rtl/nor_poll_dp.sv
module nor_poll_dp
  import nor_poll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT = 5,
  parameter int MAX_PAIRS = 1024,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         stb,
  input  logic [DATA_W-1:0] rdData,
  output logic              toggled,
  output logic              limitHit,
  output logic              pairsSpent,
  output logic [DATA_W-1:0] wrData
);

  localparam int CNT_W = $clog2(MAX_PAIRS + 1);
  localparam logic [DATA_W-1:0] TOG_MASK = DATA_W'(1) << TOGGLE_BIT;
  localparam logic [DATA_W-1:0] LIM_MASK = DATA_W'(1) << LIMIT_BIT;
  localparam logic [CNT_W-1:0] PAIR_LIMIT = CNT_W'(MAX_PAIRS);

  logic firstTog;
  logic secondTog;
  logic secondLim;
  logic [CNT_W-1:0] pairCnt;

  // only the two decision bits are kept from each read
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      firstTog  <= 1'b0;
      secondTog <= 1'b0;
      secondLim <= 1'b0;
    end else begin
      if (stb.capFirst) begin
        firstTog <= |(rdData & TOG_MASK);
      end
      if (stb.capSecond) begin
        secondTog <= |(rdData & TOG_MASK);
        secondLim <= |(rdData & LIM_MASK);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pairCnt <= '0;
    end else if (stb.clrPairs) begin
      pairCnt <= '0;
    end else if (stb.incPairs && pairCnt != PAIR_LIMIT) begin
      pairCnt <= pairCnt + CNT_W'(1);
    end
  end

  assign toggled    = firstTog ^ secondTog;
  assign limitHit   = secondLim;
  assign pairsSpent = (pairCnt == PAIR_LIMIT);
  assign wrData     = RESET_CMD;

endmodule

// File: rtl/nor_poll_ctl.sv
module nor_poll_ctl
  import nor_poll_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      rdAck,
  input  logic      wrAck,
  input  logic      toggled,
  input  logic      limitHit,
  input  logic      pairsSpent,
  output dpStrobe_t stb,
  output logic      rdReq,
  output logic      wrReq,
  output logic      busy,
  output logic      done,
  output logic      fail
);

  pollState_t curState;
  pollState_t nxtState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) curState <= ST_IDLE;
    else       curState <= nxtState;
  end

  always_comb begin
    nxtState = curState;
    stb      = '0;
    unique case (curState)
      ST_IDLE: begin
        if (start) begin
          nxtState     = ST_RD1;
          stb.clrPairs = 1'b1;
        end
      end
      ST_RD1: begin
        if (rdAck) begin
          stb.capFirst = 1'b1;
          nxtState     = ST_RD2;
        end
      end
      ST_RD2: begin
        if (rdAck) begin
          stb.capSecond = 1'b1;
          stb.incPairs  = 1'b1;
          nxtState      = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (!toggled)        nxtState = ST_DONE;
        else if (limitHit)   nxtState = ST_RC1;
        else if (pairsSpent) nxtState = ST_RSTWR;
        else                 nxtState = ST_RD1;
      end
      ST_RC1: begin
        if (rdAck) begin
          stb.capFirst = 1'b1;
          nxtState     = ST_RC2;
        end
      end
      ST_RC2: begin
        if (rdAck) begin
          stb.capSecond = 1'b1;
          nxtState      = ST_RCEVAL;
        end
      end
      ST_RCEVAL: begin
        nxtState = toggled ? ST_RSTWR : ST_DONE;
      end
      ST_RSTWR: begin
        if (wrAck) nxtState = ST_FAIL;
      end
      ST_DONE: nxtState = ST_IDLE;
      ST_FAIL: nxtState = ST_IDLE;
      default: nxtState = ST_IDLE;
    endcase
  end

  assign rdReq = (curState == ST_RD1) || (curState == ST_RD2) ||
                 (curState == ST_RC1) || (curState == ST_RC2);
  assign wrReq = (curState == ST_RSTWR);
  assign busy  = (curState != ST_IDLE);
  assign done  = (curState == ST_DONE);
  assign fail  = (curState == ST_FAIL);

endmodule

// File: rtl/nor_toggle_poller.sv
module nor_toggle_poller
  import nor_poll_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int TOGGLE_BIT = 6,
  parameter int LIMIT_BIT = 5,
  parameter int MAX_PAIRS = 1024,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  output logic              rdReq,
  input  logic              rdAck,
  input  logic [DATA_W-1:0] rdData,
  output logic              wrReq,
  input  logic              wrAck,
  output logic [DATA_W-1:0] wrData,
  output logic              busy,
  output logic              done,
  output logic              fail
);

  dpStrobe_t stb;
  logic toggled;
  logic limitHit;
  logic pairsSpent;

  nor_poll_ctl u_ctl (
    .clk(clk), .rstN(rstN), .start(start), .rdAck(rdAck), .wrAck(wrAck),
    .toggled(toggled), .limitHit(limitHit), .pairsSpent(pairsSpent),
    .stb(stb), .rdReq(rdReq), .wrReq(wrReq), .busy(busy),
    .done(done), .fail(fail)
  );

  nor_poll_dp #(
    .DATA_W(DATA_W), .TOGGLE_BIT(TOGGLE_BIT), .LIMIT_BIT(LIMIT_BIT),
    .MAX_PAIRS(MAX_PAIRS), .RESET_CMD(RESET_CMD)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .rdData(rdData),
    .toggled(toggled), .limitHit(limitHit), .pairsSpent(pairsSpent),
    .wrData(wrData)
  );

endmodule

// File: rtl/nor_poll_chk.sv
module nor_poll_chk #(
  parameter int DATA_W = 8,
  parameter logic [DATA_W-1:0] RESET_CMD = 8'hF0
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic              rdReq,
  input logic              rdAck,
  input logic              wrReq,
  input logic              wrAck,
  input logic [DATA_W-1:0] wrData,
  input logic              busy,
  input logic              done,
  input logic              fail
);

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(done && fail));
  // R8
  req_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rdReq && wrReq));
  // R8
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && !rdAck |=> rdReq);
  // R5
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq && !wrAck |=> wrReq);
  // R5
  wr_byte_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrReq |-> wrData == RESET_CMD);
  // R5
  fail_after_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |-> $past(wrReq && wrAck));
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R8
  fail_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    fail |=> !fail);
  // R7
  busy_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    start && !busy |=> busy);
  // R7
  busy_env_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done || fail || rdReq || wrReq) |-> busy);

endmodule

bind nor_toggle_poller nor_poll_chk #(.DATA_W(DATA_W), .RESET_CMD(RESET_CMD)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdAck(rdAck),
  .wrReq(wrReq), .wrAck(wrAck), .wrData(wrData), .busy(busy),
  .done(done), .fail(fail)
);

// File: tb/test_nor_toggle_poller.sv
`timescale 1ns/1ps
module test_nor_toggle_poller;

  localparam int MAXP = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic rdReq, rdAck, wrReq, wrAck, busy, done, fail;
  logic [7:0] rdData, wrData;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int ackDelay = 0;
  int readsServed = 0;
  int writesSeen = 0;
  int lastRdEdge = 0;
  int lastWrEdge = 0;
  logic [7:0] lastWrByte = 8'h00;
  logic [7:0] respQ[$];

  always #2 clk = ~clk;  // 250 MHz
  always @(posedge clk) cyc <= cyc + 1;

  nor_toggle_poller #(.MAX_PAIRS(MAXP)) i_nor_toggle_poller (
    .clk(clk), .rstN(rstN), .start(start), .rdReq(rdReq), .rdAck(rdAck),
    .rdData(rdData), .wrReq(wrReq), .wrAck(wrAck), .wrData(wrData),
    .busy(busy), .done(done), .fail(fail)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // device responder: acks after ackDelay cycles, ack lasts one cycle
  initial begin
    int rdWait = 0;
    int wrWait = 0;
    rdAck = 1'b0; wrAck = 1'b0; rdData = 8'h00;
    forever begin
      @(negedge clk);
      if (rdAck) rdAck = 1'b0;
      else if (rdReq) begin
        if (rdWait < ackDelay) rdWait++;
        else begin
          rdWait = 0;
          rdAck = 1'b1;
          rdData = (respQ.size() > 0) ? respQ.pop_front() : 8'h00;
          readsServed++;
          lastRdEdge = cyc + 1;
        end
      end
      if (wrAck) wrAck = 1'b0;
      else if (wrReq) begin
        if (wrWait < ackDelay) wrWait++;
        else begin
          wrWait = 0;
          wrAck = 1'b1;
          lastWrByte = wrData;
          writesSeen++;
          lastWrEdge = cyc + 1;
        end
      end
    end
  end

  // per-clock reference rules
  initial begin
    forever begin
      @(negedge clk);
      if (rstN) begin
        check(!(done && fail), "R8", "done and fail together", int'(done & fail), 0);
        check(busy || (!rdReq && !wrReq), "R7", "request while idle",
              int'(rdReq | wrReq), 0);
      end
    end
  end

  // behavioural reference of the polling decision
  task automatic model(input logic [7:0] seq[$], output int nReads, output bit expFail);
    int idx = 0;
    int pairs = 0;
    logic [7:0] a, b;
    nReads = 0; expFail = 0;
    forever begin
      a = (idx < seq.size()) ? seq[idx] : 8'h00; idx++;
      b = (idx < seq.size()) ? seq[idx] : 8'h00; idx++;
      pairs++;
      if (a[6] == b[6]) begin expFail = 0; break; end
      if (b[5]) begin
        a = (idx < seq.size()) ? seq[idx] : 8'h00; idx++;
        b = (idx < seq.size()) ? seq[idx] : 8'h00; idx++;
        expFail = (a[6] != b[6]);
        break;
      end
      if (pairs == MAXP) begin expFail = 1; break; end
    end
    nReads = idx;
  endtask

  task automatic runCase(input string req, input logic [7:0] seq[$],
                         input int delay, input bit extraStart);
    int expReads;
    bit expFail;
    bit sawDone = 0;
    bit sawFail = 0;
    int endCyc = 0;
    model(seq, expReads, expFail);
    respQ = seq;
    readsServed = 0; writesSeen = 0; ackDelay = delay;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    check(busy === 1'b1, "R7", "busy after start", int'(busy), 1);
    if (extraStart) begin
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    for (int i = 0; i < 500; i++) begin
      if (done || fail) begin
        sawDone = done; sawFail = fail; endCyc = cyc;
        break;
      end
      @(negedge clk);
    end
    check(sawDone == !expFail, req, "done outcome", int'(sawDone), int'(!expFail));
    check(sawFail == expFail, req, "fail outcome", int'(sawFail), int'(expFail));
    check(readsServed == expReads, req, "reads issued", readsServed, expReads);
    check(writesSeen == int'(expFail), req, "reset writes", writesSeen, int'(expFail));
    if (expFail) begin
      check(lastWrByte == 8'hF0, "R5", "reset byte", lastWrByte, 8'hF0);
      check(endCyc == lastWrEdge, "R9", "fail timing", endCyc, lastWrEdge);
    end else begin
      check(endCyc == lastRdEdge + 1, "R9", "done timing", endCyc, lastRdEdge + 1);
    end
    @(negedge clk);
    check(!done && !fail, "R8", "pulse width", int'(done | fail), 0);
    check(!busy, "R7", "busy after result", int'(busy), 0);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] s[$];
    repeat (3) @(negedge clk);
    check(!busy && !done && !fail && !rdReq && !wrReq, "R1", "reset outputs",
          int'({busy, done, fail, rdReq, wrReq}), 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !rdReq && !wrReq, "R1", "idle after reset",
          int'({busy, rdReq, wrReq}), 0);

    s = '{8'h40, 8'h40};                      runCase("R2", s, 0, 0);
    s = '{8'h00, 8'h00};                      runCase("R2", s, 3, 0);
    s = '{8'h40, 8'h00, 8'h00, 8'h00};        runCase("R3", s, 0, 0);
    // bit 5 only in first read of pair: must not trigger recheck
    s = '{8'h20, 8'h40, 8'h00, 8'h40, 8'h00, 8'h00}; runCase("R3", s, 1, 0);
    s = '{8'h40, 8'h20, 8'h60, 8'h60};        runCase("R4", s, 0, 0);
    s = '{8'h40, 8'h20, 8'h60, 8'h20};        runCase("R5", s, 0, 0);
    s = '{8'h40, 8'h20, 8'h60, 8'h20};        runCase("R5", s, 2, 0);
    s = '{8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h40};
    runCase("R6", s, 0, 1);
    s = '{8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40, 8'h00, 8'h40};
    runCase("R6", s, 2, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule